// File: doc/BRIEF.md
# Masked Content Addressable Memory

This block is a small associative store of `DEPTH` words, each `WIDTH` bits wide. Software never chooses where a word lands. A write presents only data, and the block places it in the lowest-numbered empty slot. When every slot is occupied, the block raises a full flag and refuses further writes. A slot can be retired by naming its index on the invalidate port. The slot then becomes free and is reused by later writes.

A search presents an argument word and a key word. Every key bit at 1 marks a bit position that takes part in the compare. Every key bit at 0 removes that position from the compare. All stored words are compared with the argument in the same cycle. One clock after the search strobe, a registered match vector appears, with bit `i` standing for slot `i`. A first-hit index and a hit flag are derived from that vector. The match vector holds its value until the next strobe.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY`: no slot is valid.
- `OCC_PARTIAL`: some slots are valid, but not all.
- `OCC_FULL`: every slot is valid.

The transitions are:
- `OCC_EMPTY` goes to `OCC_PARTIAL` on an accepted write. It goes straight to `OCC_FULL` instead when `DEPTH` is 1.
- `OCC_PARTIAL` goes to `OCC_FULL` when a write takes the last free slot.
- `OCC_PARTIAL` goes to `OCC_EMPTY` when the last valid slot is invalidated.
- `OCC_FULL` goes to `OCC_PARTIAL` on any invalidate of a valid slot.
- Every other case stays in the current state.

Top module: `mcam_top`

## Requirements
- R1: After reset, every slot is empty, `match_vec` is all zeros, `hit` is 0, `first_idx` is 0 and `full` is 0.
- R2: While `full` is 0, `wr_valid` gives `wr_accept` = 1 in the same cycle, and the word is stored in the lowest-numbered empty slot at the next clock edge.
- R3: `full` is 1 exactly when all `DEPTH` slots hold valid words. A write while `full` is 1 gets `wr_accept` = 0 and changes no stored word.
- R4: With `srch_key` all ones, `match_vec[i]` is 1 exactly when slot `i` is valid and its word equals `srch_arg` in every bit.
- R5: A key bit at 0 removes that bit position from the compare. `match_vec[i]` is 1 exactly when slot `i` is valid and `((word ^ srch_arg) & srch_key) == 0`.
- R6: A slot that is not valid never sets its match bit, whatever the argument and key.
- R7: `match_vec` changes only at the clock edge where `srch_go` is 1, so the result is visible one cycle after the strobe. Between strobes it holds its value, even across writes and invalidates.
- R8: When a write and a search fall in the same cycle, the search compares against the contents from before that write.
- R9: `inv_valid` with `inv_idx` makes that slot empty at the next edge. This clears `full` when it was set, and a later write reuses the lowest freed slot.
- R10: `first_idx` is the lowest index whose bit is set in `match_vec`, and `hit` is 1 when any bit is set. With no bit set, `hit` and `first_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | WIDTH | Word to store |
| wr_valid | input | 1 | Write request |
| wr_accept | output | 1 | Write taken this cycle |
| full | output | 1 | All slots occupied |
| srch_arg | input | WIDTH | Search argument |
| srch_key | input | WIDTH | Compare mask, 1 = bit position compared |
| srch_go | input | 1 | Search strobe |
| match_vec | output | DEPTH | Registered per-slot match result |
| hit | output | 1 | Any bit of match_vec set |
| first_idx | output | IDXW | Lowest matching slot index |
| inv_valid | input | 1 | Invalidate request |
| inv_idx | input | IDXW | Slot to invalidate |

## Verification
Each check below names a corner case and the failure it would expose.
- The bench stores duplicate words and then sweeps every argument against every key, computing the expected match vector arithmetically. A design that inverted the mask sense, compared a masked position, or let an empty slot match would miscompare in many vectors.
- The bench fills the store, then offers a further write. A block that overwrote a slot, or kept `full` low, would show a wrong `wr_accept` or a spurious match for the refused word.
- The bench frees slots out of order and then writes into the gap. Picking a free slot other than the lowest would show up as the wrong match bit.
- The bench issues a write and a search in the same cycle. A design that bypassed new data into the compare would report a premature hit.
- The bench holds the search strobe low while writes and invalidates proceed. A match vector that tracked live contents would be exposed by that pause.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_t;
endpackage

// File: rtl/mcam_slot_cmp.sv
// One slot's masked comparator: only key-enabled bits take part.
module mcam_slot_cmp #(
    parameter int WIDTH = 16
) (
    input  logic             slot_valid,
    input  logic [WIDTH-1:0] slot_word,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] key,
    output logic             hit
);
    logic [WIDTH-1:0] diff;

    assign diff = (slot_word ^ arg) & key;
    assign hit  = slot_valid && (diff == '0);
endmodule

// File: rtl/mcam_lowest_set.sv
// Returns the index of the lowest set bit of vec; found is 0 for an all-zero vector.
module mcam_lowest_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcam_top.sv
module mcam_top
    import mcam_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    output logic             wr_accept,
    output logic             full,
    input  logic [WIDTH-1:0] srch_arg,
    input  logic [WIDTH-1:0] srch_key,
    input  logic             srch_go,
    output logic [DEPTH-1:0] match_vec,
    output logic             hit,
    output logic [IDXW-1:0]  first_idx,
    input  logic             inv_valid,
    input  logic [IDXW-1:0]  inv_idx
);
    occ_t             state_q, state_d;
    logic [DEPTH-1:0] valid_q, valid_d;
    logic [WIDTH-1:0] word_q [DEPTH];
    logic [DEPTH-1:0] hit_now;
    logic [DEPTH-1:0] match_q;
    logic [IDXW-1:0]  free_idx;
    logic             free_found;
    logic             inv_in_range;

    // Lowest free slot for allocation.
    mcam_lowest_set #(.N(DEPTH), .IW(IDXW)) u_free (
        .vec   (~valid_q),
        .idx   (free_idx),
        .found (free_found)
    );

    // Parallel compare of every slot against the current (pre-write) contents.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        mcam_slot_cmp #(.WIDTH(WIDTH)) u_cmp (
            .slot_valid (valid_q[s]),
            .slot_word  (word_q[s]),
            .arg        (srch_arg),
            .key        (srch_key),
            .hit        (hit_now[s])
        );
    end

    // First-hit index from the registered match vector.
    mcam_lowest_set #(.N(DEPTH), .IW(IDXW)) u_first (
        .vec   (match_q),
        .idx   (first_idx),
        .found (hit)
    );

    assign inv_in_range = (int'(inv_idx) < DEPTH);

    // Next occupancy vector.
    always_comb begin
        valid_d = valid_q;
        if (inv_valid && inv_in_range) valid_d[inv_idx] = 1'b0;
        if (wr_accept)                 valid_d[free_idx] = 1'b1;
    end

    // Occupancy state transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (valid_d != '0) state_d = (&valid_d) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (&valid_d)               state_d = OCC_FULL;
                else if (valid_d == '0)     state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (!(&valid_d)) state_d = (valid_d == '0) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs decoded from state.
    always_comb begin
        full      = (state_q == OCC_FULL);
        wr_accept = wr_valid && !full;
        match_vec = match_q;
    end

    // Slot storage, occupancy and match register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            match_q <= '0;
            for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
        end else begin
            valid_q <= valid_d;
            if (wr_accept) word_q[free_idx] <= wr_data;
            if (srch_go)   match_q <= hit_now;
        end
    end

    // ---------------- assertions ----------------
    assert_full_tracks_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full == (&valid_q));

    assert_refused_write_keeps_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && !inv_valid) |=> $stable(valid_q));

    assert_write_adds_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && !inv_valid) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

    assert_no_empty_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        srch_go |=> ((match_vec & ~$past(valid_q)) == '0));

    assert_match_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_go |=> $stable(match_vec));

    assert_first_idx_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[first_idx]);

    assert_hit_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (match_vec != '0));

    assert_free_when_not_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> (free_found && !valid_q[free_idx]));
endmodule

// File: tb/sim_mcam_top.sv
`timescale 1ns/1ps
module sim_mcam_top;
    localparam int W = 4;
    localparam int D = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  wr_data;
    logic          wr_valid;
    logic          wr_accept;
    logic          full;
    logic [W-1:0]  srch_arg;
    logic [W-1:0]  srch_key;
    logic          srch_go;
    logic [D-1:0]  match_vec;
    logic          hit;
    logic [IW-1:0] first_idx;
    logic          inv_valid;
    logic [IW-1:0] inv_idx;

    int vectors = 0;
    int fails   = 0;

    logic [W-1:0] m_word [D];
    logic [D-1:0] m_val;

    always #4 clk = ~clk;

    mcam_top #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_accept(wr_accept), .full(full), .srch_arg(srch_arg), .srch_key(srch_key),
        .srch_go(srch_go), .match_vec(match_vec), .hit(hit), .first_idx(first_idx),
        .inv_valid(inv_valid), .inv_idx(inv_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [D-1:0] exp_match(input logic [W-1:0] a, input logic [W-1:0] k);
        logic [D-1:0] r = '0;
        for (int i = 0; i < D; i++)
            r[i] = m_val[i] && (((m_word[i] ^ a) & k) == '0);
        return r;
    endfunction

    function automatic int low_bit(input logic [D-1:0] v);
        for (int i = 0; i < D; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int model_write(input logic [W-1:0] d);
        for (int i = 0; i < D; i++)
            if (!m_val[i]) begin
                m_val[i] = 1'b1;
                m_word[i] = d;
                return 1;
            end
        return 0;
    endfunction

    task automatic do_write(input logic [W-1:0] d, input string tag);
        int ok;
        wr_data = d;
        wr_valid = 1'b1;
        #1;
        ok = (m_val != '1) ? 1 : 0;
        chk(tag, int'(wr_accept), ok);
        step();
        wr_valid = 1'b0;
        if (ok == 1) void'(model_write(d));
    endtask

    task automatic do_search(input logic [W-1:0] a, input logic [W-1:0] k, input string tag);
        logic [D-1:0] e;
        e = exp_match(a, k);
        srch_arg = a;
        srch_key = k;
        srch_go = 1'b1;
        step();
        srch_go = 1'b0;
        chk(tag, int'(match_vec), int'(e));
        chk("R10 hit", int'(hit), (e != '0) ? 1 : 0);
        chk("R10 first_idx", int'(first_idx), low_bit(e));
    endtask

    task automatic do_inv(input int idx);
        inv_idx = IW'(idx);
        inv_valid = 1'b1;
        step();
        inv_valid = 1'b0;
        m_val[idx] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [D-1:0] held;
        rst_n = 1'b0; wr_data = '0; wr_valid = 1'b0; srch_arg = '0; srch_key = '0;
        srch_go = 1'b0; inv_valid = 1'b0; inv_idx = '0;
        m_val = '0;
        for (int i = 0; i < D; i++) m_word[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 match_vec", int'(match_vec), 0);
        chk("R1 hit", int'(hit), 0);
        chk("R1 first_idx", int'(first_idx), 0);
        chk("R1 full", int'(full), 0);
        do_search(4'h0, 4'h0, "R1 empty store");

        // R2 fill with a duplicate word
        do_write(4'h3, "R2 accept");
        do_write(4'h5, "R2 accept");
        do_write(4'h3, "R2 accept");
        chk("R3 not full yet", int'(full), 0);
        do_write(4'hC, "R2 accept");
        chk("R3 full", int'(full), 1);
        do_search(4'h5, 4'hF, "R2 placement slot1");
        do_search(4'hC, 4'hF, "R2 placement slot3");

        // R3 refused write leaves contents unchanged
        do_write(4'h7, "R3 refused");
        do_search(4'h7, 4'hF, "R3 no store when full");

        // R4 R5 R10 exhaustive sweep
        for (int a = 0; a < 16; a++)
            for (int k = 0; k < 16; k++)
                do_search(W'(a), W'(k), (k == 15) ? "R4 full key" : "R5 masked");

        // R7 result holds between strobes
        do_search(4'h3, 4'hF, "R7 strobe");
        held = match_vec;
        srch_arg = 4'hC;
        srch_key = 4'hF;
        do_inv(0);
        step();
        chk("R7 hold after inval", int'(match_vec), int'(held));
        do_write(4'hC, "R2 accept reuse");
        chk("R7 hold after write", int'(match_vec), int'(held));

        // R9 invalidate frees slot, lowest reused
        do_inv(1);
        do_inv(2);
        chk("R9 full cleared", int'(full), 0);
        do_search(4'h5, 4'hF, "R9 freed slot gone");

        // R8 same-cycle write and search
        wr_data = 4'h9; wr_valid = 1'b1;
        srch_arg = 4'h9; srch_key = 4'hF; srch_go = 1'b1;
        #1;
        chk("R2 accept same cycle", int'(wr_accept), 1);
        step();
        wr_valid = 1'b0; srch_go = 1'b0;
        chk("R8 search sees old contents", int'(match_vec), 0);
        void'(model_write(4'h9));
        do_search(4'h9, 4'hF, "R8 new word now visible");
        chk("R9 lowest reused slot1", int'(first_idx), 1);
        do_write(4'hB, "R2 accept");
        do_search(4'hB, 4'hF, "R9 next free slot2");

        // R6 sweep with one empty slot
        do_inv(3);
        for (int a = 0; a < 16; a++)
            for (int k = 0; k < 16; k++)
                do_search(W'(a), W'(k), "R6 empty slot never matches");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule